// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit descriptor engine of an Ethernet MAC. Software builds a ring of 8-byte descriptors in memory. Each descriptor has an address word and a status word. Software sets a queue base address and then writes the control word with both the enable bit and the start bit set. The engine then walks the ring from the base address. For each descriptor it reads the referenced buffer one word at a time over a simple memory port and sends the bytes out on a byte stream. It marks the final byte of the buffer flagged as last. When a frame ends, well or badly, it writes ownership and error flags back into the first descriptor of that frame.

A descriptor whose used flag is set ends the walk. Software therefore places such a descriptor after the last real one. The walk also ends early in two cases. If the chain runs out before a last-flagged buffer, the engine records buffer exhaustion. If the stream sink is not ready when a byte is due, the engine records an underrun. A frame that completes sets a done flag in the transmit-status word, and software clears that flag by writing 1 to it.

Top module: `tx_desc_ring_reader`

## Requirements
- R1: A control write (csr_sel=0) that has both bit 9 (start) and bit 3 (enable) set starts a walk at the queue base address. A start without bit 3 does nothing, and a start written while a walk is running is ignored.
- R2: A descriptor is two words at consecutive addresses. Word 0 is the buffer byte address. Word 1 is the status word: length in bits 10:0, last-buffer flag in bit 15, wrap flag in bit 30, used flag in bit 31. The queue base is written with csr_sel=2, and its low 3 bits are forced to zero.
- R3: Buffer bytes leave in ascending address order, one byte per cycle in which tx_valid and tx_ready are both high. A buffer may start at any byte alignment. Byte k of a memory word is bits 8k+7:8k of that word.
- R4: tx_last is high only together with the final byte of a buffer whose last flag is set.
- R5: A used descriptor met outside a frame ends the walk with no memory write and no change to the done flag.
- R6: When a frame completes, bit 31 is set in the status word of that frame's first descriptor, and its other bits are kept. No other descriptor is written.
- R7: If a used descriptor is met after the start of a frame but before its last buffer, the first descriptor's status gets bits 31 and 27 set. The walk stops and the done flag stays clear.
- R8: If tx_valid is high while tx_ready is low, the frame is aborted. tx_valid drops on the next cycle, the first descriptor's status gets bits 31 and 28 set, the walk stops, and the done flag stays clear.
- R9: A descriptor with the wrap flag set makes the next descriptor fetch go to the queue base address instead of the following 8 bytes.
- R10: Frame completion sets bit 5 of tx_status. A status write (csr_sel=1) with bit 5 at 1 clears it, and bit 5 at 0 leaves it unchanged.
- R11: After reset, tx_valid and mem_req are low and tx_status is zero.
- R12: Every memory address is word aligned. Reads return data one cycle after the request, and writes only occur with mem_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 control, 1 status, 2 queue base |
| csr_wdata | input | 32 | Register write data |
| tx_status | output | 32 | Transmit status, done flag in bit 5 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (status writeback) |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink ready; low while tx_valid is high is an underrun |

## Verification
A wrong ring pointer shows up within one descriptor. Bytes come from the wrong buffer, or the descriptor past a wrap gets sent, so a bad stream byte or an extra byte count appears in the frame where the fault occurs. A frame-tracking fault shows up when the frame ends. The writeback lands on a descriptor other than the first, carries the wrong flag set, or is missing, and the done flag is wrong in the same check. A byte-lane or byte-count slip changes the captured bytes or moves the last marker, and this is visible in the first buffer that is not word aligned or does not end on a word boundary.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // status word bit positions shared with software
  localparam int B_LAST = 15;
  localparam int B_EXH  = 27;
  localparam int B_UNDR = 28;
  localparam int B_WRAP = 30;
  localparam int B_USED = 31;
  // control and status register bits
  localparam int C_TXEN  = 3;
  localparam int C_START = 9;
  localparam int S_DONE  = 5;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2
  } csr_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_A, ST_RD_S, ST_CHK, ST_RD_W, ST_LD_W, ST_SEND, ST_NEXT, ST_WB
  } eng_state_e;

  function automatic logic [31:0] flag_bit(input int pos);
    return 32'(1) << pos;
  endfunction
endpackage

// File: rtl/txr_csr.sv
module txr_csr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  input  logic              busy,
  input  logic              done_evt,
  output logic              start_evt,
  output logic [ADDR_W-1:0] base_addr,
  output logic [31:0]       status_o
);
  import txr_pkg::*;

  logic              done_q;
  logic [ADDR_W-1:0] base_q;
  logic              wr_ctrl, wr_stat, wr_base;
  logic              unused_wbits;

  assign wr_ctrl = csr_we && (csr_sel == SEL_CTRL);
  assign wr_stat = csr_we && (csr_sel == SEL_STAT);
  assign wr_base = csr_we && (csr_sel == SEL_BASE);

  assign start_evt = wr_ctrl && csr_wdata[C_START] && csr_wdata[C_TXEN] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      base_q <= '0;
    end else begin
      if (done_evt)
        done_q <= 1'b1;
      else if (wr_stat && csr_wdata[S_DONE])
        done_q <= 1'b0;
      if (wr_base)
        base_q <= {csr_wdata[ADDR_W-1:3], 3'b000};
    end
  end

  assign base_addr = base_q;
  assign status_o  = 32'(done_q) << S_DONE;
  assign unused_wbits = ^{csr_wdata[31:ADDR_W], csr_wdata[2:0]};
endmodule

// File: rtl/txr_lane_mux.sv
module txr_lane_mux #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]              word_i,
  input  logic [$clog2(WORD_W/8)-1:0]    sel_i,
  output logic [7:0]                     byte_o
);
  localparam int LANES = WORD_W / 8;

  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [31:0]       word_o,
  output logic [1:0]        lane_o,
  output logic              busy,
  output logic              done_evt,
  output logic              underrun_evt,
  output logic              exhaust_evt
);
  import txr_pkg::*;

  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;

  eng_state_e        st, st_after;
  logic [ADDR_W-1:0] ptr, buf_addr, first_ptr, byte_addr;
  logic [31:0]       first_stat, word_q, wb_flags;
  logic [LEN_W-1:0]  cur_len, cnt;
  logic              cur_last, cur_wrap, in_frame, final_byte;

  // next descriptor address: wrap returns to the queue base
  function automatic logic [ADDR_W-1:0] ring_next(input logic [ADDR_W-1:0] p,
                                                  input logic wrap,
                                                  input logic [ADDR_W-1:0] b);
    return wrap ? b : p + ADDR_W'(DESC_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic is_final(input logic [LEN_W-1:0] c, input logic [LEN_W-1:0] l);
    return ({1'b0, c} + 1'b1) == {1'b0, l};
  endfunction

  assign byte_addr  = buf_addr + ADDR_W'(cnt);
  assign lane_o     = byte_addr[1:0];
  assign word_o     = word_q;
  assign final_byte = is_final(cnt, cur_len);

  assign busy         = (st != ST_IDLE);
  assign tx_valid     = (st == ST_SEND);
  assign tx_last      = tx_valid && cur_last && final_byte;
  assign underrun_evt = tx_valid && !tx_ready;
  assign exhaust_evt  = (st == ST_CHK) && mem_rdata[B_USED] && in_frame;
  assign done_evt     = (st == ST_NEXT) && cur_last;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = first_stat | wb_flags;
    case (st)
      ST_RD_A: begin mem_req = 1'b1; mem_addr = ptr; end
      ST_RD_S: begin mem_req = 1'b1; mem_addr = ptr + ADDR_W'(STAT_OFS); end
      ST_RD_W: begin mem_req = 1'b1; mem_addr = word_of(byte_addr); end
      ST_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = first_ptr + ADDR_W'(STAT_OFS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      st_after   <= ST_IDLE;
      ptr        <= '0;
      buf_addr   <= '0;
      first_ptr  <= '0;
      first_stat <= '0;
      word_q     <= '0;
      wb_flags   <= '0;
      cur_len    <= '0;
      cnt        <= '0;
      cur_last   <= 1'b0;
      cur_wrap   <= 1'b0;
      in_frame   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_evt) begin
            ptr      <= base_addr;
            in_frame <= 1'b0;
            st       <= ST_RD_A;
          end
        end
        ST_RD_A: st <= ST_RD_S;
        ST_RD_S: begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          st       <= ST_CHK;
        end
        ST_CHK: begin
          if (mem_rdata[B_USED]) begin
            if (in_frame) begin
              wb_flags <= flag_bit(B_USED) | flag_bit(B_EXH);
              st_after <= ST_IDLE;
              in_frame <= 1'b0;
              st       <= ST_WB;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cur_len  <= mem_rdata[LEN_W-1:0];
            cur_last <= mem_rdata[B_LAST];
            cur_wrap <= mem_rdata[B_WRAP];
            if (!in_frame) begin
              first_ptr  <= ptr;
              first_stat <= mem_rdata;
            end
            in_frame <= 1'b1;
            cnt      <= '0;
            st       <= (mem_rdata[LEN_W-1:0] == '0) ? ST_NEXT : ST_RD_W;
          end
        end
        ST_RD_W: st <= ST_LD_W;
        ST_LD_W: begin
          word_q <= mem_rdata;
          st     <= ST_SEND;
        end
        ST_SEND: begin
          if (!tx_ready) begin
            wb_flags <= flag_bit(B_USED) | flag_bit(B_UNDR);
            st_after <= ST_IDLE;
            in_frame <= 1'b0;
            st       <= ST_WB;
          end else begin
            cnt <= cnt + 1'b1;
            if (final_byte)
              st <= ST_NEXT;
            else if (&lane_o)
              st <= ST_RD_W;
          end
        end
        ST_NEXT: begin
          ptr <= ring_next(ptr, cur_wrap, base_addr);
          if (cur_last) begin
            wb_flags <= flag_bit(B_USED);
            st_after <= ST_RD_A;
            in_frame <= 1'b0;
            st       <= ST_WB;
          end else begin
            st <= ST_RD_A;
          end
        end
        ST_WB: st <= st_after;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_ring_reader.sv
module tx_desc_ring_reader #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       tx_status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam int WORD_W = 32;

  logic              start_evt, busy, done_evt, underrun_evt, exhaust_evt;
  logic [ADDR_W-1:0] base_addr;
  logic [WORD_W-1:0] cur_word;
  logic [1:0]        cur_lane;

  txr_csr #(.ADDR_W(ADDR_W)) i_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .busy      (busy),
    .done_evt  (done_evt),
    .start_evt (start_evt),
    .base_addr (base_addr),
    .status_o  (tx_status)
  );

  txr_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_evt    (start_evt),
    .base_addr    (base_addr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .word_o       (cur_word),
    .lane_o       (cur_lane),
    .busy         (busy),
    .done_evt     (done_evt),
    .underrun_evt (underrun_evt),
    .exhaust_evt  (exhaust_evt)
  );

  txr_lane_mux #(.WORD_W(WORD_W)) i_lane (
    .word_i (cur_word),
    .sel_i  (cur_lane),
    .byte_o (tx_data)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] addr_lo,
  input logic       tx_valid,
  input logic       tx_last,
  input logic       tx_ready,
  input logic       done_evt,
  input logic       underrun_evt,
  input logic       exhaust_evt,
  input logic       done_flag,
  input logic       done_clr_req
);
  // R4: the last marker rides only on a delivered byte
  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R8: a missed byte ends the stream at once
  a_r8_underrun_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> !tx_valid);

  // R8: the abort is followed by the status writeback
  a_r8_underrun_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> (mem_req && mem_we));

  // R7: exhaustion is followed by the status writeback
  a_r7_exhaust_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_evt |=> (mem_req && mem_we));

  // R10: completion raises the done flag
  a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_flag);

  // R10: write-one-to-clear with no competing completion
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr_req && !done_evt) |=> !done_flag);

  // R12: aligned accesses, writes only as requests
  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (addr_lo == 2'b00));

  a_r12_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R5: an idle engine is silent on both ports
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));
endmodule

bind tx_desc_ring_reader txr_checker i_txr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .addr_lo      (mem_addr[1:0]),
  .tx_valid     (tx_valid),
  .tx_last      (tx_last),
  .tx_ready     (tx_ready),
  .done_evt     (done_evt),
  .underrun_evt (underrun_evt),
  .exhaust_evt  (exhaust_evt),
  .done_flag    (tx_status[5]),
  .done_clr_req (csr_we && (csr_sel == 2'd1) && csr_wdata[5])
);

// File: tb/test_tx_desc_ring_reader.sv
module test_tx_desc_ring_reader;
  localparam int ADDR_W = 16;
  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] UNDR = 32'h1000_0000;
  localparam logic [31:0] EXH  = 32'h0800_0000;
  localparam logic [31:0] LAST = 32'h0000_8000;
  localparam logic [31:0] GO   = 32'h0000_0208;
  localparam int BASE = 'h100;
  localparam int BUF0 = 'h400;
  localparam int BUF1 = 'h600;

  // {len0[11], align0[2], len1[11] (0 = single buffer), expected bytes[12]}
  localparam logic [35:0] VEC [6] = '{
    {11'd5, 2'd0, 11'd0, 12'd5},
    {11'd4, 2'd0, 11'd0, 12'd4},
    {11'd9, 2'd1, 11'd0, 12'd9},
    {11'd1, 2'd3, 11'd0, 12'd1},
    {11'd6, 2'd2, 11'd7, 12'd13},
    {11'd3, 2'd3, 11'd4, 12'd7}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              csr_we = 1'b0;
  logic [1:0]        csr_sel = 2'd0;
  logic [31:0]       csr_wdata = '0;
  logic [31:0]       tx_status;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;
  logic              tx_valid, tx_last;
  logic [7:0]        tx_data;
  logic              tx_ready = 1'b1;

  logic [31:0] mem [1024];
  logic [7:0]  cap_d [512];
  logic        cap_l [512];
  int          cap_n = 0;
  int          vcnt = 0;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done_run = 1'b0;

  always #2.5 clk = ~clk;

  tx_desc_ring_reader #(.ADDR_W(ADDR_W)) i_tx_desc_ring_reader (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .tx_status(tx_status), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 5 + 17) & 255);
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      vcnt = vcnt + 1;
      if (tx_ready) begin
        cap_d[cap_n] = tx_data;
        cap_l[cap_n] = tx_last;
        cap_n = cap_n + 1;
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done_run) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_sel = sel; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] s);
    mem[at >> 2]       <= a;
    mem[(at >> 2) + 1] <= s;
  endtask

  task automatic clear_done();
    csr_write(2'd1, 32'h20);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++)
      mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    wait_cyc(3);
    // R11: reset state
    chk("R11 tx_valid", 32'(tx_valid), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 tx_status", tx_status, 0);
    rst_n = 1'b1;
    csr_write(2'd2, BASE + 3);   // R2: low bits dropped, base = 0x100

    // vector table walk: R2, R3, R4, R6, R10
    for (int v = 0; v < 6; v++) begin
      int l0, o0, l1, ex, i0, bad, lbad;
      logic [31:0] s0, s1;
      l0 = int'(VEC[v][35:25]); o0 = int'(VEC[v][24:23]);
      l1 = int'(VEC[v][22:12]); ex = int'(VEC[v][11:0]);
      s0 = 32'(l0) | ((l1 == 0) ? LAST : 32'h0);
      s1 = 32'(l1) | LAST;
      put_desc(BASE, 32'(BUF0 + o0), s0);
      if (l1 != 0) begin
        put_desc(BASE + 8, BUF1, s1);
        put_desc(BASE + 16, 0, USED | WRAP);
      end else begin
        put_desc(BASE + 8, 0, USED | WRAP);
      end
      i0 = cap_n;
      csr_write(2'd0, GO);
      wait_cyc(300);
      chk("R3 byte count", 32'(cap_n - i0), 32'(ex));
      bad = 0; lbad = 0;
      for (int k = 0; k < ex; k++) begin
        int a;
        a = (k < l0) ? (BUF0 + o0 + k) : (BUF1 + k - l0);
        if (cap_d[i0 + k] !== pat(a)) bad++;
        if (cap_l[i0 + k] !== (k == ex - 1)) lbad++;
      end
      chk("R3 byte values", 32'(bad), 0);
      chk("R4 last marker", 32'(lbad), 0);
      chk("R6 first desc used", mem[(BASE >> 2) + 1], s0 | USED);
      if (l1 != 0) chk("R6 second desc untouched", mem[(BASE >> 2) + 3], s1);
      chk("R10 done set", tx_status, 32'h20);
      csr_write(2'd1, 32'h0);
      chk("R10 write 0 keeps done", tx_status, 32'h20);
      clear_done();
      chk("R10 write 1 clears done", tx_status, 32'h0);
    end

    // R1: start without enable does nothing
    begin
      int i0, v0;
      put_desc(BASE, BUF0, 32'd3 | LAST);
      put_desc(BASE + 8, 0, USED);
      i0 = cap_n; v0 = vcnt;
      csr_write(2'd0, 32'h200);
      wait_cyc(100);
      chk("R1 no enable, no bytes", 32'(vcnt - v0), 0);
      chk("R1 no enable, desc unchanged", mem[(BASE >> 2) + 1], 32'd3 | LAST);
      chk("R1 no enable, no done", tx_status, 0);
      // R1: a second start while running is ignored
      put_desc(BASE, BUF0, 32'd11 | LAST);
      csr_write(2'd0, GO);
      wait_cyc(4);
      csr_write(2'd0, GO);
      wait_cyc(300);
      chk("R1 restart ignored, bytes", 32'(cap_n - i0), 11);
      clear_done();
    end

    // R4/R6: two frames back to back
    begin
      int i0;
      put_desc(BASE, BUF0, 32'd2 | LAST);
      put_desc(BASE + 8, BUF1 + 1, 32'd3 | LAST);
      put_desc(BASE + 16, 0, USED);
      i0 = cap_n;
      csr_write(2'd0, GO);
      wait_cyc(300);
      chk("R3 two frames count", 32'(cap_n - i0), 5);
      chk("R4 two frames last pattern",
          {27'd0, cap_l[i0+4], cap_l[i0+3], cap_l[i0+2], cap_l[i0+1], cap_l[i0]}, 32'b10010);
      chk("R3 second frame byte", 32'(cap_d[i0 + 2]), 32'(pat(BUF1 + 1)));
      chk("R6 frame one used", mem[(BASE >> 2) + 1], 32'd2 | LAST | USED);
      chk("R6 frame two used", mem[(BASE >> 2) + 3], 32'd3 | LAST | USED);
      clear_done();
    end

    // R7: chain ends inside a frame
    begin
      int i0, lc;
      put_desc(BASE, BUF0, 32'd4);
      put_desc(BASE + 8, 0, USED | 32'd9);
      i0 = cap_n;
      csr_write(2'd0, GO);
      wait_cyc(200);
      chk("R7 bytes before exhaustion", 32'(cap_n - i0), 4);
      lc = 0;
      for (int k = 0; k < 4; k++) if (cap_l[i0 + k]) lc++;
      chk("R7 no last marker", 32'(lc), 0);
      chk("R7 first desc flags", mem[(BASE >> 2) + 1], 32'd4 | USED | EXH);
      chk("R7 terminator untouched", mem[(BASE >> 2) + 3], USED | 32'd9);
      chk("R7 done clear", tx_status, 0);
    end

    // R8: sink not ready
    begin
      int i0, v0;
      tx_ready = 1'b0;
      put_desc(BASE, BUF0, 32'd4 | LAST);
      put_desc(BASE + 8, 0, USED);
      i0 = cap_n; v0 = vcnt;
      csr_write(2'd0, GO);
      wait_cyc(200);
      chk("R8 one valid cycle", 32'(vcnt - v0), 1);
      chk("R8 nothing accepted", 32'(cap_n - i0), 0);
      chk("R8 first desc flags", mem[(BASE >> 2) + 1], 32'd4 | LAST | USED | UNDR);
      chk("R8 done clear", tx_status, 0);
      tx_ready = 1'b1;
    end

    // R9: wrap returns to base, next slot never fetched
    begin
      int i0;
      put_desc(BASE, BUF0 + 2, 32'd3 | LAST | WRAP);
      put_desc(BASE + 8, BUF1, 32'd5 | LAST);
      i0 = cap_n;
      csr_write(2'd0, GO);
      wait_cyc(300);
      chk("R9 only wrapped frame sent", 32'(cap_n - i0), 3);
      chk("R9 slot after wrap untouched", mem[(BASE >> 2) + 3], 32'd5 | LAST);
      chk("R9 wrap desc used", mem[(BASE >> 2) + 1], 32'd3 | LAST | WRAP | USED);
      clear_done();
    end

    // R5: used descriptor at the head, nothing happens
    begin
      int v0;
      put_desc(BASE, BUF0, USED | 32'd6 | LAST);
      v0 = vcnt;
      csr_write(2'd0, GO);
      wait_cyc(100);
      chk("R5 no bytes", 32'(vcnt - v0), 0);
      chk("R5 desc unchanged", mem[(BASE >> 2) + 1], USED | 32'd6 | LAST);
      chk("R5 done clear", tx_status, 0);
    end

    done_run = 1'b1;
    summary();
    $finish;
  end
endmodule